// File: doc/BRIEF.md
# Buffered-Update PWM Channel

This block is one pulse-width-modulation channel. A free-running counter advances on each cycle where an externally supplied clock enable (`tick`) is high. The counter is compared against a duty register to form the output waveform. Two counting shapes are available. In edge-aligned form the counter ramps up and wraps to zero after reaching the period value. In symmetric form it climbs to the period value and then descends, so the period register sets half of the output period.

When the channel is idle, software loads the period and duty registers directly. Once the channel runs, those direct loads are refused. A change then goes through a single staging register whose destination (duty or period) is latched at the moment it is written. The staged value moves into its destination only at a period boundary, so the waveform never shows a torn cycle. At most one of the two quantities can change per period, and a newer staged write replaces an older one that has not yet been applied. Each period boundary is signalled by a one-cycle `period_end` pulse.

Top module: `pwm_chan`

## Requirements
- R1: On synchronous reset, `pwm_out` and `period_end` are 0, the counter, period and duty registers are 0, and nothing is staged.
- R2: While `chan_en` is 0, the counter is held at 0, `period_end` stays 0, `pwm_out` shows the idle level equal to `pol` (one cycle later), and `wr_period`/`wr_duty` load `wr_data` into period/duty on the next edge.
- R3: While `chan_en` is 1, `wr_period` and `wr_duty` have no effect on the waveform.
- R4: With `center`=0 the counter runs 0,1,...,P and then clears to 0, so a period lasts P+1 ticks; the boundary is the tick that clears it, and `period_end` is high for the one cycle right after that edge.
- R5: With `center`=1 the counter runs 0,1,...,P,P-1,...,1,0, so a period lasts 2P ticks; the boundary is the tick on which the down-count reaches 0.
- R6: `pwm_out` is registered. For `pol`=0 it is 0 in the cycle after the counter was below duty, and 1 otherwise. `pol`=1 inverts it.
- R7: The counter changes only on cycles where `tick` is 1.
- R8: `wr_upd` stages `wr_data` together with the target `upd_sel` (0 = duty, 1 = period). The staged value is copied to its target at the next period boundary, and the staging is then emptied.
- R9: A second `wr_upd` before the boundary replaces both the staged value and its target.
- R10: A `wr_upd` in the same cycle as a boundary does not take part in that boundary. It stays staged and is applied at the following one.
- R11: With period 0 the counter stays at 0 and every tick is a boundary, in either counting shape.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Counter clock enable |
| chan_en | input | 1 | Channel run enable |
| center | input | 1 | 0 edge-aligned, 1 symmetric up/down |
| pol | input | 1 | Output polarity |
| upd_sel | input | 1 | Staging target: 0 duty, 1 period |
| wr_period | input | 1 | Direct period load (idle only) |
| wr_duty | input | 1 | Direct duty load (idle only) |
| wr_upd | input | 1 | Write staging register |
| wr_data | input | 16 | Data for all writes |
| pwm_out | output | 1 | Waveform |
| period_end | output | 1 | One-cycle pulse after each period boundary |

## Verification
Two functions can meet in one cycle: a staging write and a period boundary that should consume the previous staged value. The bench provokes this by timing `wr_upd` from a measured `period_end` pulse, so that the write is sampled on exactly the boundary tick. It then judges the result by the gaps between the next two pulses: the first gap must still show the old period, and the second gap must show the new one. A cycle-by-cycle behavioural model also compares both outputs on every clock.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  typedef enum logic {DIR_UP = 1'b0, DIR_DOWN = 1'b1} cnt_dir_t;
  typedef enum logic {TGT_DUTY = 1'b0, TGT_PERIOD = 1'b1} upd_tgt_t;
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         chan_en,
  input  logic         wr_period,
  input  logic         wr_duty,
  input  logic         wr_upd,
  input  logic         upd_sel,
  input  logic [W-1:0] wr_data,
  input  logic         bound_evt,
  output logic [W-1:0] prd_q,
  output logic [W-1:0] duty_q
);
  logic         stg_full;
  logic [W-1:0] stg_val;
  upd_tgt_t     stg_tgt;

  // Destination registers: staged transfer at a boundary, direct loads when idle
  always_ff @(posedge clk) begin
    if (rst) begin
      prd_q  <= '0;
      duty_q <= '0;
    end else if (bound_evt && stg_full) begin
      if (stg_tgt == TGT_PERIOD) prd_q  <= stg_val;
      else                       duty_q <= stg_val;
    end else if (!chan_en) begin
      if (wr_period) prd_q  <= wr_data;
      if (wr_duty)   duty_q <= wr_data;
    end
  end

  // Staging register: newest write wins, emptied when consumed
  always_ff @(posedge clk) begin
    if (rst) begin
      stg_full <= 1'b0;
      stg_val  <= '0;
      stg_tgt  <= TGT_DUTY;
    end else if (wr_upd) begin
      stg_full <= 1'b1;
      stg_val  <= wr_data;
      stg_tgt  <= upd_sel ? TGT_PERIOD : TGT_DUTY;
    end else if (bound_evt) begin
      stg_full <= 1'b0;
    end
  end
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter
  import pwm_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         chan_en,
  input  logic         tick,
  input  logic         center,
  input  logic [W-1:0] prd_q,
  output logic [W-1:0] cnt_q,
  output logic         bound_evt
);
  localparam logic [W-1:0] ONE = W'(1);

  cnt_dir_t     dir_q, dir_d;
  logic [W-1:0] cnt_d;
  logic         evt_d;

  always_comb begin
    cnt_d = cnt_q;
    dir_d = dir_q;
    evt_d = 1'b0;
    if (!center) begin
      dir_d = DIR_UP;
      if (cnt_q >= prd_q) begin
        cnt_d = '0;
        evt_d = 1'b1;
      end else begin
        cnt_d = cnt_q + ONE;
      end
    end else if (dir_q == DIR_UP && cnt_q < prd_q) begin
      cnt_d = cnt_q + ONE;
    end else if (cnt_q == '0) begin
      dir_d = DIR_UP;
      evt_d = 1'b1;
    end else begin
      cnt_d = cnt_q - ONE;
      if (cnt_q == ONE) begin
        dir_d = DIR_UP;
        evt_d = 1'b1;
      end else begin
        dir_d = DIR_DOWN;
      end
    end
  end

  assign bound_evt = chan_en && tick && evt_d;

  always_ff @(posedge clk) begin
    if (rst || !chan_en) begin
      cnt_q <= '0;
      dir_q <= DIR_UP;
    end else if (tick) begin
      cnt_q <= cnt_d;
      dir_q <= dir_d;
    end
  end
endmodule

// File: rtl/pwm_wave.sv
module pwm_wave #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         chan_en,
  input  logic         pol,
  input  logic [W-1:0] cnt_q,
  input  logic [W-1:0] duty_q,
  input  logic         bound_evt,
  output logic         pwm_out,
  output logic         period_end
);
  logic at_or_above;
  assign at_or_above = (cnt_q >= duty_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      pwm_out    <= 1'b0;
      period_end <= 1'b0;
    end else begin
      pwm_out    <= chan_en ? (at_or_above ^ pol) : pol;
      period_end <= bound_evt;
    end
  end
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             chan_en,
  input  logic             center,
  input  logic             pol,
  input  logic             upd_sel,
  input  logic             wr_period,
  input  logic             wr_duty,
  input  logic             wr_upd,
  input  logic [CNT_W-1:0] wr_data,
  output logic             pwm_out,
  output logic             period_end
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] prd_q;
  logic [CNT_W-1:0] duty_q;
  logic             bound_evt;

  pwm_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .chan_en(chan_en), .tick(tick), .center(center),
    .prd_q(prd_q), .cnt_q(cnt_q), .bound_evt(bound_evt)
  );

  pwm_regs #(.W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .chan_en(chan_en), .wr_period(wr_period),
    .wr_duty(wr_duty), .wr_upd(wr_upd), .upd_sel(upd_sel), .wr_data(wr_data),
    .bound_evt(bound_evt), .prd_q(prd_q), .duty_q(duty_q)
  );

  pwm_wave #(.W(CNT_W)) u_wave (
    .clk(clk), .rst(rst), .chan_en(chan_en), .pol(pol), .cnt_q(cnt_q),
    .duty_q(duty_q), .bound_evt(bound_evt), .pwm_out(pwm_out),
    .period_end(period_end)
  );
endmodule

// File: rtl/pwm_chan_chk.sv
module pwm_chan_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             tick,
  input logic             chan_en,
  input logic             pol,
  input logic             pwm_out,
  input logic             period_end,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] prd_q,
  input logic             bound_evt
);
  p_idle_level_r2: assert property (@(posedge clk) disable iff (rst)
    !chan_en |=> pwm_out == $past(pol));

  p_no_end_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !chan_en |=> !period_end);

  p_hold_no_tick_r7: assert property (@(posedge clk) disable iff (rst)
    (chan_en && !tick) |=> cnt_q == $past(cnt_q));

  p_cnt_in_range_r4: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= prd_q);

  p_end_at_zero_r4: assert property (@(posedge clk) disable iff (rst)
    period_end |-> cnt_q == '0);

  // R3 and R8: a running channel changes its period only at a boundary
  p_prd_only_at_bound_r8: assert property (@(posedge clk) disable iff (rst)
    (chan_en && !bound_evt) |=> $stable(prd_q));
endmodule

bind pwm_chan pwm_chan_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/sim_pwm_chan.sv
module sim_pwm_chan;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        chan_en = 1'b0;
  logic        center = 1'b0;
  logic        pol = 1'b0;
  logic        upd_sel = 1'b0;
  logic        wr_period = 1'b0;
  logic        wr_duty = 1'b0;
  logic        wr_upd = 1'b0;
  logic [15:0] wr_data = '0;
  logic        pwm_out;
  logic        period_end;

  int n_checks = 0;
  int n_fail = 0;
  int tick_div = 1;
  int tick_ph = 0;
  string phase = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_chan u0 (
    .clk(clk), .rst(rst), .tick(tick), .chan_en(chan_en), .center(center),
    .pol(pol), .upd_sel(upd_sel), .wr_period(wr_period), .wr_duty(wr_duty),
    .wr_upd(wr_upd), .wr_data(wr_data), .pwm_out(pwm_out), .period_end(period_end)
  );

  // tick generator: high once every tick_div cycles
  always @(negedge clk) begin
    tick_ph = (tick_ph + 1 >= tick_div) ? 0 : tick_ph + 1;
    tick <= (tick_ph == 0);
  end

  // behavioural reference model
  int  m_cnt, m_prd, m_duty, m_sval;
  bit  m_down, m_full, m_stgt, m_valid;
  bit  e_out, e_end;
  always @(posedge clk) begin
    bit evt;
    int nc;
    bit nd;
    if (rst) begin
      m_cnt = 0; m_down = 0; m_prd = 0; m_duty = 0;
      m_full = 0; m_sval = 0; m_stgt = 0;
      e_out = 0; e_end = 0;
    end else begin
      evt = 0; nc = m_cnt; nd = m_down;
      if (chan_en && tick) begin
        if (!center) begin
          nd = 0;
          if (m_cnt >= m_prd) begin nc = 0; evt = 1; end
          else nc = m_cnt + 1;
        end else if (!m_down && m_cnt < m_prd) begin
          nc = m_cnt + 1;
        end else if (m_cnt == 0) begin
          nd = 0; evt = 1;
        end else begin
          nc = m_cnt - 1;
          nd = (nc != 0);
          evt = (nc == 0);
        end
      end
      e_out = chan_en ? ((m_cnt >= m_duty) ^ pol) : pol;
      e_end = evt;
      if (evt && m_full) begin
        if (m_stgt) m_prd = m_sval; else m_duty = m_sval;
      end else if (!chan_en) begin
        if (wr_period) m_prd = int'(wr_data);
        if (wr_duty)   m_duty = int'(wr_data);
      end
      if (wr_upd) begin m_full = 1; m_sval = int'(wr_data); m_stgt = upd_sel; end
      else if (evt) m_full = 0;
      if (!chan_en) begin nc = 0; nd = 0; end
      m_cnt = nc; m_down = nd;
    end
    m_valid = 1;
  end

  always @(negedge clk) begin
    if (m_valid) begin
      n_checks++;
      if (pwm_out !== e_out || period_end !== e_end) begin
        n_fail++;
        $display("FAIL %s model: out=%0b end=%0b expected out=%0b end=%0b",
                 phase, pwm_out, period_end, e_out, e_end);
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_end();
    do @(negedge clk); while (!period_end);
  endtask

  // measures ticks-cycles between two pulses and high samples over that window
  task automatic measure(output int gap, output int hi);
    wait_end();
    gap = 0; hi = 0;
    do begin
      @(negedge clk);
      gap++;
      if (pwm_out) hi++;
    end while (!period_end);
  endtask

  task automatic direct(input bit is_prd, input int v);
    wr_data = 16'(v);
    wr_period = is_prd; wr_duty = !is_prd;
    @(negedge clk);
    wr_period = 0; wr_duty = 0;
  endtask

  task automatic stage(input bit sel, input int v);
    wr_data = 16'(v); upd_sel = sel; wr_upd = 1;
    @(negedge clk);
    wr_upd = 0;
  endtask

  initial begin
    int g, h, cnt;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1 out", int'(pwm_out), 0);
    check("R1 end", int'(period_end), 0);

    phase = "R2";
    direct(1, 4); direct(0, 2);
    pol = 1; repeat (3) @(negedge clk);
    check("R2 idle pol1", int'(pwm_out), 1);
    pol = 0; @(negedge clk); @(negedge clk);
    check("R2 idle pol0", int'(pwm_out), 0);

    phase = "R4";
    chan_en = 1;
    measure(g, h); measure(g, h);
    check("R4 gap", g, 5);
    check("R6 high pol0", h, 3);

    phase = "R3";
    direct(1, 9); direct(0, 0);
    measure(g, h); measure(g, h);
    check("R3 gap", g, 5);
    check("R3 high", h, 3);

    phase = "R6";
    pol = 1;
    measure(g, h); measure(g, h);
    check("R6 high pol1", h, 2);

    phase = "R9";
    wait_end();
    stage(1, 6); stage(0, 1);
    measure(g, h); measure(g, h);
    check("R9 gap", g, 5);
    check("R9 high", h, 1);

    phase = "R8";
    stage(1, 7);
    measure(g, h); measure(g, h);
    check("R8 gap", g, 8);

    phase = "R10";
    wait_end();
    repeat (7) @(negedge clk);
    wr_data = 16'd3; upd_sel = 1; wr_upd = 1;
    @(negedge clk);
    wr_upd = 0;
    check("R10 boundary seen", int'(period_end), 1);
    g = 0;
    do begin @(negedge clk); g++; end while (!period_end);
    check("R10 old gap", g, 8);
    g = 0;
    do begin @(negedge clk); g++; end while (!period_end);
    check("R10 new gap", g, 4);

    phase = "R5";
    chan_en = 0; pol = 0; center = 1;
    @(negedge clk);
    direct(1, 4); direct(0, 2);
    chan_en = 1;
    measure(g, h); measure(g, h);
    check("R5 gap", g, 8);
    check("R5 high", h, 5);

    phase = "R7";
    tick_div = 3;
    measure(g, h); measure(g, h);
    check("R7 gap", g, 24);
    tick_div = 1;
    measure(g, h);

    phase = "R11";
    chan_en = 0; @(negedge clk);
    direct(1, 0); direct(0, 0);
    chan_en = 1;
    measure(g, h); measure(g, h);
    check("R11 center gap", g, 1);
    center = 0;
    measure(g, h); measure(g, h);
    check("R11 left gap", g, 1);

    phase = "R2";
    chan_en = 0; pol = 1;
    @(negedge clk);
    cnt = 0;
    repeat (10) begin @(negedge clk); if (period_end) cnt++; end
    check("R2 no pulse idle", cnt, 0);
    check("R2 idle level", int'(pwm_out), 1);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule